// File: doc/BRIEF.md
# E3 Overhead Alarm and Interrupt Monitor

This block sits behind an E3 receive framer that has already found frame alignment. It watches a byte stream in which each byte carries a tag (FA1, FA2, EM, MA, NR, GC or payload) and a start-of-frame strobe. From the overhead bytes it builds a set of alarm and error events:
- a filtered far-end receive failure (FERF) state taken from the MA byte,
- framing-byte errors,
- BIP-8 errors, found by comparing each frame's EM byte with the parity of the frame before it,
- payload-type changes from one frame to the next.

Each event sets a sticky status bit. Software reads the status through a read strobe, and the strobe clears the bits. A single interrupt line is the OR of the status bits whose enables are set. The block also forwards one data-link octet per frame, taken from NR or GC as a control input selects.

Top module: `e3oh_monitor`

## Requirements
- R1: After reset, `stat_q`, `irq`, `ferf_alarm` and `dl_vld` are all 0.
- R2: `ferf_alarm` goes to 1 only after the FERF bit (bit 7 of the MA byte) has been 1 in N consecutive frames. N is 3 when `cfg_ferf5` is 0 and 5 when it is 1. A 0 in between restarts the count.
- R3: `ferf_alarm` returns to 0 only after the FERF bit has been 0 in N consecutive frames, with N chosen as in R2.
- R4: Every change of `ferf_alarm`, onset and end alike, sets status bit 3 (`stat_q[3]`) in the cycle after the change.
- R5: An FA1 byte other than 0xF6, or an FA2 byte other than 0x28, sets status bit 1 two cycles after that byte is sampled.
- R6: When the payload-type field (bits 5..3 of the MA byte) differs from the previous frame's, status bit 0 is set. The first MA byte after reset is never compared.
- R7: When the EM byte of a frame differs from the XOR of every byte of the previous frame, status bit 2 is set. Both frames are counted from their start-of-frame byte. The first frame after reset is not checked.
- R8: Status bits stay set until a cycle with `stat_rd` high. That read clears them in the next cycle, except for a bit whose event arrives in the same cycle.
- R9: `irq` is high exactly when some status bit is set and its bit in `irq_en` is 1.
- R10: When `cfg_dl_nr` is 1, every NR byte appears on `dl_byte` with `dl_vld` high one cycle after it is sampled. When `cfg_dl_nr` is 0, GC bytes are forwarded the same way instead. Tag codes are: payload 0, FA1 1, FA2 2, EM 3, MA 4, NR 5, GC 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_in | input | 8 | Received byte |
| byte_vld | input | 1 | Byte strobe |
| byte_tag | input | 3 | Overhead tag of the byte |
| sof | input | 1 | First byte of a frame |
| cfg_ferf5 | input | 1 | FERF persistence: 0 selects 3 frames, 1 selects 5 |
| cfg_dl_nr | input | 1 | Data-link source: 1 selects NR, 0 selects GC |
| irq_en | input | 4 | Interrupt enable per status bit |
| stat_rd | input | 1 | Status read strobe (clears the status) |
| stat_q | output | 4 | Sticky status: [3] FERF change, [2] BIP-8, [1] framing, [0] payload type |
| irq | output | 1 | Interrupt request |
| ferf_alarm | output | 1 | Filtered FERF state |
| dl_byte | output | 8 | Forwarded data-link octet |
| dl_vld | output | 1 | Data-link octet strobe |

## Verification
The stimulus is a stream of whole frames.
- Clean frames, with a deliberately wrong EM byte in the very first frame, show that the first-frame parity and payload-type checks are skipped.
- Single faults in FA1, FA2, EM or the payload-type field show that each fault reaches only its own status bit.
- FERF runs of exactly N, one short of N, and broken by a single opposite frame, with both the 3-frame and the 5-frame setting, separate a true persistence filter from an edge detector or a plain count.
- Enable masks that include or exclude the pending bit, alternate NR/GC selection, and two faulty frames with no read between them cover the interrupt, the forwarding and the sticky clearing.

// File: rtl/e3oh_pkg.sv
// Shared types for the E3 overhead monitor.
// Assumes: tag codes are fixed by the upstream aligner and match this enum.
package e3oh_pkg;
    typedef enum logic [2:0] {
        TAG_PAY = 3'd0,
        TAG_FA1 = 3'd1,
        TAG_FA2 = 3'd2,
        TAG_EM  = 3'd3,
        TAG_MA  = 3'd4,
        TAG_NR  = 3'd5,
        TAG_GC  = 3'd6
    } oh_tag_e;

    localparam int STAT_NB   = 4;
    localparam int ST_PT     = 0;
    localparam int ST_FRAME  = 1;
    localparam int ST_BIP    = 2;
    localparam int ST_FERF   = 3;
endpackage

// File: rtl/e3oh_ferf_filter.sv
// FERF persistence filter.
// Counts consecutive frames whose FERF bit disagrees with the current alarm
// state; the alarm flips when that run reaches the selected length.
// Assumes: ma_stb pulses once per frame, with the MA byte.
module e3oh_ferf_filter #(
    parameter int NSHORT = 3,
    parameter int NLONG  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ma_stb,
    input  logic ferf_bit,
    input  logic long_sel,
    output logic alarm,
    output logic change
);
    localparam int CW = $clog2(NLONG + 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_inc;
    logic [CW-1:0] limit;

    assign limit   = long_sel ? CW'(NLONG) : CW'(NSHORT);
    assign run_inc = run_q + CW'(1);

    // Advance the opposing-run counter and flip the alarm at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            alarm  <= 1'b0;
            change <= 1'b0;
        end else begin
            change <= 1'b0;
            if (ma_stb) begin
                if (ferf_bit != alarm) begin
                    if (run_inc >= limit) begin
                        alarm  <= ferf_bit;
                        change <= 1'b1;
                        run_q  <= '0;
                    end else begin
                        run_q  <= run_inc;
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/e3oh_frame_check.sv
// Per-frame byte checks: framing bytes, BIP-8 against the next EM byte,
// payload-type change between frames. Emits one-cycle registered events.
// Assumes: sof comes with a valid byte, and EM is not the first byte of a frame.
module e3oh_frame_check
    import e3oh_pkg::*;
#(
    parameter int          DW      = 8,
    parameter logic [DW-1:0] FA1_VAL = 8'hF6,
    parameter logic [DW-1:0] FA2_VAL = 8'h28,
    parameter int          PT_HI   = 5,
    parameter int          PT_LO   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] byte_in,
    input  logic          byte_vld,
    input  oh_tag_e       tag,
    input  logic          sof,
    output logic          fa_err,
    output logic          bip_err,
    output logic          pt_chg
);
    localparam int PTW = PT_HI - PT_LO + 1;

    logic [DW-1:0]  acc_q;
    logic [DW-1:0]  prev_q;
    logic           prev_ok_q;
    logic           in_frame_q;
    logic [PTW-1:0] pt_q;
    logic           pt_ok_q;

    // Running parity of the current frame and the final parity of the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            prev_q     <= '0;
            prev_ok_q  <= 1'b0;
            in_frame_q <= 1'b0;
        end else if (byte_vld) begin
            if (sof) begin
                prev_q     <= acc_q;
                prev_ok_q  <= in_frame_q;
                acc_q      <= byte_in;
                in_frame_q <= 1'b1;
            end else begin
                acc_q <= acc_q ^ byte_in;
            end
        end
    end

    // Payload type memory for the frame-to-frame comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q    <= '0;
            pt_ok_q <= 1'b0;
        end else if (byte_vld && tag == TAG_MA) begin
            pt_q    <= byte_in[PT_HI:PT_LO];
            pt_ok_q <= 1'b1;
        end
    end

    // Registered error events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fa_err  <= 1'b0;
            bip_err <= 1'b0;
            pt_chg  <= 1'b0;
        end else begin
            fa_err  <= byte_vld &&
                       ((tag == TAG_FA1 && byte_in != FA1_VAL) ||
                        (tag == TAG_FA2 && byte_in != FA2_VAL));
            bip_err <= byte_vld && tag == TAG_EM && prev_ok_q && byte_in != prev_q;
            pt_chg  <= byte_vld && tag == TAG_MA && pt_ok_q &&
                       byte_in[PT_HI:PT_LO] != pt_q;
        end
    end
endmodule

// File: rtl/e3oh_irq_regs.sv
// Sticky status bits cleared by a read strobe, and the masked interrupt OR.
// Assumes: an event in the read cycle survives the clear.
module e3oh_irq_regs #(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] evt,
    input  logic          rd,
    input  logic [NB-1:0] en,
    output logic [NB-1:0] stat,
    output logic          irq
);
    genvar gi;
    generate
        for (gi = 0; gi < NB; gi++) begin : g_bit
            // Hold one sticky status bit.
            always_ff @(posedge clk) begin
                if (!rst_n) stat[gi] <= 1'b0;
                else        stat[gi] <= evt[gi] | (stat[gi] & ~rd);
            end
        end
    endgenerate

    // Combine enabled status bits into the interrupt line.
    always_comb irq = |(stat & en);
endmodule

// File: rtl/e3oh_monitor.sv
// E3 overhead alarm and interrupt monitor (top).
// Takes an aligned, tagged byte stream; produces a filtered FERF alarm,
// sticky status with interrupt, and the selected data-link octet.
// Assumes: frame alignment is done upstream; one MA, EM, NR and GC per frame.
module e3oh_monitor
    import e3oh_pkg::*;
#(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] FA1_VAL  = 8'hF6,
    parameter logic [DW-1:0] FA2_VAL  = 8'h28,
    parameter int            FERF_BIT = 7,
    parameter int            NSHORT   = 3,
    parameter int            NLONG    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DW-1:0]      byte_in,
    input  logic               byte_vld,
    input  logic [2:0]         byte_tag,
    input  logic               sof,
    input  logic               cfg_ferf5,
    input  logic               cfg_dl_nr,
    input  logic [STAT_NB-1:0] irq_en,
    input  logic               stat_rd,
    output logic [STAT_NB-1:0] stat_q,
    output logic               irq,
    output logic               ferf_alarm,
    output logic [DW-1:0]      dl_byte,
    output logic               dl_vld
);
    oh_tag_e            tag;
    logic               ma_stb;
    logic               ferf_chg;
    logic               fa_err;
    logic               bip_err;
    logic               pt_chg;
    logic [STAT_NB-1:0] evt;
    logic               dl_pick;

    assign tag    = oh_tag_e'(byte_tag);
    assign ma_stb = byte_vld && tag == TAG_MA;

    e3oh_ferf_filter #(.NSHORT(NSHORT), .NLONG(NLONG)) u_ferf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ma_stb   (ma_stb),
        .ferf_bit (byte_in[FERF_BIT]),
        .long_sel (cfg_ferf5),
        .alarm    (ferf_alarm),
        .change   (ferf_chg)
    );

    e3oh_frame_check #(.DW(DW), .FA1_VAL(FA1_VAL), .FA2_VAL(FA2_VAL)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (byte_in),
        .byte_vld (byte_vld),
        .tag      (tag),
        .sof      (sof),
        .fa_err   (fa_err),
        .bip_err  (bip_err),
        .pt_chg   (pt_chg)
    );

    // Map events onto their status bit positions.
    always_comb begin
        evt           = '0;
        evt[ST_FERF]  = ferf_chg;
        evt[ST_BIP]   = bip_err;
        evt[ST_FRAME] = fa_err;
        evt[ST_PT]    = pt_chg;
    end

    e3oh_irq_regs #(.NB(STAT_NB)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .rd    (stat_rd),
        .en    (irq_en),
        .stat  (stat_q),
        .irq   (irq)
    );

    assign dl_pick = byte_vld && (cfg_dl_nr ? (tag == TAG_NR) : (tag == TAG_GC));

    // Forward the selected data-link octet with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_byte <= '0;
            dl_vld  <= 1'b0;
        end else begin
            dl_vld <= dl_pick;
            if (dl_pick) dl_byte <= byte_in;
        end
    end
endmodule

// File: rtl/e3oh_monitor_chk.sv
// Assertion checker for e3oh_monitor, attached by bind.
module e3oh_monitor_chk #(
    parameter logic [7:0] FA1_VAL = 8'hF6
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] byte_in,
    input logic       byte_vld,
    input logic [2:0] byte_tag,
    input logic       cfg_dl_nr,
    input logic       stat_rd,
    input logic [3:0] stat_q,
    input logic       ferf_alarm,
    input logic       dl_vld
);
    // R2: the alarm moves only on the cycle after an MA byte
    a_r2_alarm_on_ma: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ferf_alarm) |-> $past(byte_vld && byte_tag == 3'd4));

    // R4: onset flags the change bit
    a_r4_onset_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferf_alarm) |=> stat_q[3]);

    // R4: end of alarm flags the change bit
    a_r4_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ferf_alarm) |=> stat_q[3]);

    // R5: bad FA1 reaches the framing status bit
    a_r5_fa1_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_tag == 3'd1 && byte_in != FA1_VAL) |=> ##1 stat_q[1]);

    // R8: without a read, no set bit drops
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R10: forwarded octet came from the selected overhead byte
    a_r10_dl_src: assert property (@(posedge clk) disable iff (!rst_n)
        dl_vld |-> ($past(byte_vld) &&
                    $past(byte_tag) == ($past(cfg_dl_nr) ? 3'd5 : 3'd6)));
endmodule

bind e3oh_monitor e3oh_monitor_chk #(.FA1_VAL(FA1_VAL)) u_e3oh_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_in    (byte_in),
    .byte_vld   (byte_vld),
    .byte_tag   (byte_tag),
    .cfg_dl_nr  (cfg_dl_nr),
    .stat_rd    (stat_rd),
    .stat_q     (stat_q),
    .ferf_alarm (ferf_alarm),
    .dl_vld     (dl_vld)
);

// File: tb/e3oh_monitor_test.sv
// Scoreboard bench for e3oh_monitor: the frame driver pushes expected
// data-link octets into a queue, a monitor pops them on dl_vld.
module e3oh_monitor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = '0;
    logic       byte_vld = 1'b0;
    logic [2:0] byte_tag = '0;
    logic       sof = 1'b0;
    logic       cfg_ferf5 = 1'b0;
    logic       cfg_dl_nr = 1'b1;
    logic [3:0] irq_en = '0;
    logic       stat_rd = 1'b0;
    logic [3:0] stat_q;
    logic       irq;
    logic       ferf_alarm;
    logic [7:0] dl_byte;
    logic       dl_vld;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] acc;
    logic [7:0] prev_bip = '0;
    bit   have_prev = 1'b0;
    logic [7:0] seed = 8'h3C;

    always #2.5 clk = ~clk;

    e3oh_monitor uut (
        .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
        .byte_tag(byte_tag), .sof(sof), .cfg_ferf5(cfg_ferf5),
        .cfg_dl_nr(cfg_dl_nr), .irq_en(irq_en), .stat_rd(stat_rd),
        .stat_q(stat_q), .irq(irq), .ferf_alarm(ferf_alarm),
        .dl_byte(dl_byte), .dl_vld(dl_vld)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare each forwarded octet against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && dl_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected octet", dl_byte, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(dl_byte == e, "R10 data-link octet", dl_byte, e);
            end
        end
    end

    task automatic put(input logic [2:0] t, input logic [7:0] b, input logic s);
        byte_tag = t;
        byte_in  = b;
        sof      = s;
        byte_vld = 1'b1;
        acc      = s ? b : (acc ^ b);
        if ((cfg_dl_nr && t == 3'd5) || (!cfg_dl_nr && t == 3'd6)) exp_q.push_back(b);
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] fa1, input logic [7:0] fa2,
                              input logic [7:0] ma, input bit em_bad);
        logic [7:0] em;
        em = (have_prev ? prev_bip : 8'h5A) ^ (em_bad ? 8'h01 : 8'h00);
        put(3'd1, fa1, 1'b1);
        put(3'd2, fa2, 1'b0);
        put(3'd3, em, 1'b0);
        put(3'd4, ma, 1'b0);
        seed = seed * 8'd5 + 8'd1;
        put(3'd5, seed, 1'b0);
        seed = seed * 8'd5 + 8'd1;
        put(3'd6, seed, 1'b0);
        for (int i = 0; i < 6; i++) begin
            seed = seed * 8'd5 + 8'd1;
            put(3'd0, seed, 1'b0);
        end
        byte_vld  = 1'b0;
        sof       = 1'b0;
        prev_bip  = acc;
        have_prev = 1'b1;
    endtask

    task automatic good(input logic [7:0] ma);
        send_frame(8'hF6, 8'h28, ma, 1'b0);
    endtask

    // Wait for the pipeline, compare status and alarm, then read-clear.
    task automatic rd_status(input logic [3:0] es, input logic ea, input string req);
        repeat (3) @(negedge clk);
        check(stat_q == es, req, stat_q, es);
        check(ferf_alarm == ea, {req, " alarm"}, ferf_alarm, ea);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(stat_q == 4'h0, "R1 status", stat_q, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(ferf_alarm == 1'b0, "R1 alarm", ferf_alarm, 0);
        check(dl_vld == 1'b0, "R1 dl_vld", dl_vld, 0);

        // R7/R6: first frame has a wrong EM, but no compare yet
        send_frame(8'hF6, 8'h28, 8'h10, 1'b1);
        rd_status(4'h0, 1'b0, "R7 first frame skipped");
        good(8'h10);
        rd_status(4'h0, 1'b0, "R5 clean frame");

        // R5 framing byte faults
        send_frame(8'hF7, 8'h28, 8'h10, 1'b0);
        rd_status(4'h2, 1'b0, "R5 FA1 error");
        send_frame(8'hF6, 8'h29, 8'h10, 1'b0);
        rd_status(4'h2, 1'b0, "R5 FA2 error");

        // R7 parity fault
        send_frame(8'hF6, 8'h28, 8'h10, 1'b1);
        rd_status(4'h4, 1'b0, "R7 BIP-8 error");

        // R6 payload type change, then steady again
        good(8'h18);
        rd_status(4'h1, 1'b0, "R6 payload type change");
        good(8'h18);
        rd_status(4'h0, 1'b0, "R6 same payload type");

        // R2 broken run of ones never declares (N=3)
        good(8'h98); good(8'h98); good(8'h18); good(8'h98); good(8'h98);
        rd_status(4'h0, 1'b0, "R2 broken run");
        // R2/R4 third consecutive one declares
        good(8'h98);
        rd_status(4'h8, 1'b1, "R4 onset flag");
        // R3 two zeros keep it, third clears
        good(8'h18); good(8'h18);
        rd_status(4'h0, 1'b1, "R3 two zeros hold");
        good(8'h18);
        rd_status(4'h8, 1'b0, "R4 end flag");

        // R2 five-frame filter
        cfg_ferf5 = 1'b1;
        good(8'h98); good(8'h98); good(8'h98); good(8'h98);
        rd_status(4'h0, 1'b0, "R2 four of five");
        good(8'h98);
        rd_status(4'h8, 1'b1, "R2 fifth frame declares");
        good(8'h18); good(8'h18); good(8'h18); good(8'h18);
        rd_status(4'h0, 1'b1, "R3 four zeros hold");
        good(8'h18);
        rd_status(4'h8, 1'b0, "R3 fifth zero clears");
        cfg_ferf5 = 1'b0;

        // R8 sticky across frames without read, then cleared by read
        send_frame(8'h00, 8'h28, 8'h18, 1'b0);
        good(8'h18);
        repeat (3) @(negedge clk);
        check(stat_q == 4'h2, "R8 sticky without read", stat_q, 2);
        rd_status(4'h2, 1'b0, "R8 read value");
        check(stat_q == 4'h0, "R8 cleared after read", stat_q, 0);

        // R9 masking
        irq_en = 4'b0100;
        send_frame(8'h00, 8'h28, 8'h18, 1'b0);
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R9 masked bit", irq, 0);
        irq_en = 4'b0010;
        @(negedge clk);
        check(irq == 1'b1, "R9 enabled bit", irq, 1);
        rd_status(4'h2, 1'b0, "R9 status");
        check(irq == 1'b0, "R9 irq after read", irq, 0);
        irq_en = 4'b0000;

        // R10 GC source
        cfg_dl_nr = 1'b0;
        good(8'h18); good(8'h18);
        rd_status(4'h0, 1'b0, "R10 GC frames clean");
        cfg_dl_nr = 1'b1;
        good(8'h18);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 all octets seen", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule